// File: doc/BRIEF.md
# UART FIFO Control and DMA Request Logic

This block sits between the host register interface of a 16550-style UART and its serial engine. It holds the FIFO control byte and two character queues, one for transmit and one for receive. The host loads transmit characters and reads received ones. The serial side takes characters out of the transmit queue with a pop strobe and delivers received characters with a push strobe. From the fill levels of the two queues the block derives a receive-trigger interrupt, a transmit-space interrupt, and two active-low DMA request lines, one for each direction.

When the FIFOs are disabled, each queue behaves as a one-deep holding register. When they are enabled, each queue holds up to `DEPTH` characters. A mode bit selects how the DMA request lines behave. In single-transfer signalling a request tracks the presence of one character or one free slot. In block signalling the transmit request tracks free space in the queue. In block signalling the receive request asserts at the programmed trigger level and stays asserted until the receive queue has been drained.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFOs are disabled, single-transfer signalling is selected, the trigger code is 00 and both queues are empty. The outputs are txrdy_n=0, rxrdy_n=1, irq_tx_req=1, irq_rx_trig=0, rx_overrun=0 and tx_pending=0.
- R2: A host write with host_wsel=1 loads the control byte. Bit 0 enables the FIFOs. Bit 3 selects block signalling when 1. Bits 7:6 hold the trigger code. Bits 5:4 have no effect. A write that changes bit 0 empties both queues.
- R3: With the FIFOs enabled each queue accepts up to DEPTH (16) characters and delivers them oldest first. host_rdata and tx_char show the oldest entry of their queue.
- R4: With the FIFOs disabled each queue holds one character. A second character that arrives before the first is taken is discarded.
- R5: A receive push into a full receive queue discards the new character and sets rx_overrun. rx_overrun stays set until reset or a receive flush.
- R6: A transmit write (host_wsel=0) into a full transmit queue is ignored, and the queued contents are unchanged.
- R7: Control bit 1 empties the receive queue and clears rx_overrun. Control bit 2 empties the transmit queue. Both act only during the write that carries them and are not stored.
- R8: irq_rx_trig is high while the receive count is at or above the trigger level. The codes map as 00=1, 01=4, 10=8, 11=14 characters, and the level is 1 when the FIFOs are disabled. Characters are still accepted past the trigger until the queue is full.
- R9: irq_tx_req is high when the transmit queue is empty in single-transfer signalling, or when it has at least one free entry in block signalling.
- R10: In single-transfer signalling, txrdy_n is low exactly when the transmit queue is empty. It goes high in the cycle after the first character is written.
- R11: In single-transfer signalling, rxrdy_n is low exactly when at least one received character is waiting.
- R12: In block signalling, txrdy_n is low while the transmit queue has a free entry and high when it is full.
- R13: In block signalling, rxrdy_n goes low when the receive count reaches the trigger level and stays low until the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_wsel | input | 1 | 1 = control byte, 0 = transmit character |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, takes the oldest received character |
| host_rdata | output | 8 | Oldest received character |
| tx_pop | input | 1 | Serial side takes the oldest transmit character |
| tx_char | output | 8 | Oldest transmit character |
| tx_pending | output | 1 | Transmit queue is not empty |
| rx_push | input | 1 | Serial side delivers a received character |
| rx_char | input | 8 | Received character |
| irq_rx_trig | output | 1 | Receive count at or above the trigger level |
| irq_tx_req | output | 1 | Transmit-side interrupt request |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
A wrong queue count shows at the ports in the cycle after the offending strobe. The DMA lines and interrupts are decoded directly from the counts, so a lost or duplicated character moves txrdy_n, rxrdy_n or a trigger edge one character early or late. A corrupted pointer shows up only when the character is read out, through a wrong value at host_rdata or tx_char. The bench therefore compares every drained character with its expected value. A stuck block-mode hold flag stays hidden until the receive count falls below the trigger while it is still above zero. The hysteresis check drains the queue through exactly that window.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        TRIG_MIN  = 2'b00,
        TRIG_QTR  = 2'b01,
        TRIG_HALF = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_sel_e;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_BLOCK  = 1'b1
    } dma_sig_e;

    typedef struct packed {
        trig_sel_e trig;
        dma_sig_e  sig;
        logic      fifo_on;
    } ctrl_t;

    // Unpack a control byte; bits 5:4 are discarded, bits 2:1 are strobes.
    function automatic ctrl_t decode_ctrl(input char_t b);
        ctrl_t c;
        c.fifo_on = b[0];
        c.sig     = dma_sig_e'(b[3]);
        c.trig    = trig_sel_e'(b[7:6]);
        return c;
    endfunction

    // Trigger level in characters for a queue of the given depth.
    function automatic int unsigned trig_chars(input trig_sel_e t, input int unsigned depth);
        case (t)
            TRIG_MIN:  return 1;
            TRIG_QTR:  return depth / 4;
            TRIG_HALF: return depth / 2;
            default:   return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  char_t            wdata,
    input  logic [CNT_W-1:0] cap,
    output char_t            rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             dropped
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    char_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic             do_push, do_pop;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dropped = push && !do_push && !flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             block_mode,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_level,
    output logic             txrdy_n,
    output logic             rxrdy_n,
    output logic             irq_tx,
    output logic             irq_rx
);
    logic rx_burst_q;
    logic tx_room, tx_empty, rx_empty;

    assign tx_room  = (tx_count < CNT_W'(DEPTH));
    assign tx_empty = (tx_count == '0);
    assign rx_empty = (rx_count == '0);
    assign irq_rx   = (rx_count >= rx_level);

    // Block signalling: once the trigger is reached, hold the request until drained.
    always_ff @(posedge clk) begin
        if (rst || !block_mode || rx_empty) rx_burst_q <= 1'b0;
        else if (irq_rx)                    rx_burst_q <= 1'b1;
    end

    always_comb begin
        if (block_mode) begin
            irq_tx  = tx_room;
            txrdy_n = !tx_room;
            rxrdy_n = !(irq_rx || (rx_burst_q && !rx_empty));
        end else begin
            irq_tx  = tx_empty;
            txrdy_n = !tx_empty;
            rxrdy_n = rx_empty;
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_wsel,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    input  logic       tx_pop,
    output logic [7:0] tx_char,
    output logic       tx_pending,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    output logic       irq_rx_trig,
    output logic       irq_tx_req,
    output logic       txrdy_n,
    output logic       rxrdy_n,
    output logic       rx_overrun
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    ctrl_t            ctrl_q, ctrl_new;
    logic             ctrl_wr, thr_wr, en_change;
    logic             flush_rx, flush_tx, block_mode;
    logic [CNT_W-1:0] cap, rx_level, tx_count, rx_count;
    logic             tx_full, tx_empty, tx_drop;
    logic             rx_full, rx_empty, rx_drop;

    assign ctrl_new   = decode_ctrl(host_wdata);
    assign ctrl_wr    = host_wr && host_wsel;
    assign thr_wr     = host_wr && !host_wsel;
    assign en_change  = ctrl_wr && (ctrl_new.fifo_on != ctrl_q.fifo_on);
    assign flush_rx   = ctrl_wr && (host_wdata[1] || en_change);
    assign flush_tx   = ctrl_wr && (host_wdata[2] || en_change);
    assign block_mode = ctrl_q.fifo_on && (ctrl_q.sig == DMA_BLOCK);
    assign cap        = ctrl_q.fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
    assign rx_level   = ctrl_q.fifo_on ? CNT_W'(trig_chars(ctrl_q.trig, DEPTH)) : CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_rx) rx_overrun <= 1'b0;
        else if (rx_drop)    rx_overrun <= 1'b1;
    end

    uart_char_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) tx_q_i (
        .clk(clk), .rst(rst), .flush(flush_tx),
        .push(thr_wr), .pop(tx_pop), .wdata(host_wdata), .cap(cap),
        .rdata(tx_char), .count(tx_count), .full(tx_full), .empty(tx_empty),
        .dropped(tx_drop)
    );

    uart_char_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) rx_q_i (
        .clk(clk), .rst(rst), .flush(flush_rx),
        .push(rx_push), .pop(host_rd), .wdata(rx_char), .cap(cap),
        .rdata(host_rdata), .count(rx_count), .full(rx_full), .empty(rx_empty),
        .dropped(rx_drop)
    );

    uart_dma_req #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dma_i (
        .clk(clk), .rst(rst), .block_mode(block_mode),
        .tx_count(tx_count), .rx_count(rx_count), .rx_level(rx_level),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
        .irq_tx(irq_tx_req), .irq_rx(irq_rx_trig)
    );

    assign tx_pending = !tx_empty;

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_wsel,
    input logic [7:0]       host_wdata,
    input logic             host_rd,
    input logic             tx_pop,
    input logic             rx_push,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_full,
    input logic             rx_full,
    input logic             flush_rx,
    input logic             block_mode,
    input logic             txrdy_n,
    input logic             rxrdy_n,
    input logic             rx_overrun
);
    p_rx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CNT_W'(DEPTH));

    p_tx_full_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_wsel && tx_full && !tx_pop |=> $stable(tx_count));

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (rst)
        rx_push && rx_full && !host_rd && !flush_rx |=> rx_overrun);

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        rx_overrun && !flush_rx |=> rx_overrun);

    p_rx_flush_r7: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_wsel && host_wdata[1] |=> rx_count == '0);

    p_txrdy_release_r10: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_wsel && !block_mode && !tx_full |=> txrdy_n);

    p_rxrdy_assert_r11: assert property (@(posedge clk) disable iff (rst)
        rx_push && !block_mode && !host_rd && !(host_wr && host_wsel) |=> !rxrdy_n);

    p_rxrdy_hold_r13: assert property (@(posedge clk) disable iff (rst)
        block_mode && !rxrdy_n && (rx_count > CNT_W'(1)) && !(host_wr && host_wsel) |=> !rxrdy_n);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wsel(host_wsel),
    .host_wdata(host_wdata), .host_rd(host_rd), .tx_pop(tx_pop), .rx_push(rx_push),
    .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .rx_full(rx_full),
    .flush_rx(flush_rx), .block_mode(block_mode), .txrdy_n(txrdy_n),
    .rxrdy_n(rxrdy_n), .rx_overrun(rx_overrun)
);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr, host_wsel, host_rd, tx_pop, rx_push;
    logic [7:0] host_wdata, rx_char, host_rdata, tx_char;
    logic       tx_pending, irq_rx_trig, irq_tx_req, txrdy_n, rxrdy_n, rx_overrun;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_fifo_ctl #(.DEPTH(16)) dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wsel(host_wsel),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_pop(tx_pop), .tx_char(tx_char), .tx_pending(tx_pending),
        .rx_push(rx_push), .rx_char(rx_char), .irq_rx_trig(irq_rx_trig),
        .irq_tx_req(irq_tx_req), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
        .rx_overrun(rx_overrun)
    );

    // {trigger code[8:7], pushes[6:2], expect irq_rx_trig[1], expect rxrdy_n[0]}, block signalling
    localparam logic [8:0] VECS [8] = '{
        {2'd0, 5'd1,  1'b1, 1'b0},
        {2'd1, 5'd3,  1'b0, 1'b1},
        {2'd1, 5'd4,  1'b1, 1'b0},
        {2'd2, 5'd7,  1'b0, 1'b1},
        {2'd2, 5'd8,  1'b1, 1'b0},
        {2'd3, 5'd13, 1'b0, 1'b1},
        {2'd3, 5'd14, 1'b1, 1'b0},
        {2'd3, 5'd16, 1'b1, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        host_wr = 1'b1; host_wsel = 1'b1; host_wdata = d;
        tick();
        host_wr = 1'b0; host_wsel = 1'b0;
    endtask

    task automatic wr_thr(input logic [7:0] d);
        host_wr = 1'b1; host_wsel = 1'b0; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_char = d;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] d);
        d = tx_char;
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic rd_rx(output logic [7:0] d);
        d = host_rdata;
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; host_wr = 0; host_wsel = 0; host_wdata = 0; host_rd = 0;
        tx_pop = 0; rx_push = 0; rx_char = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 txrdy_n", txrdy_n, 0);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 irq_tx_req", irq_tx_req, 1);
        chk("R1 irq_rx_trig", irq_rx_trig, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 tx_pending", tx_pending, 0);

        // R8 and R13: trigger levels in block signalling
        foreach (VECS[i]) begin
            wr_ctrl({VECS[i][8:7], 6'b001111});
            for (int k = 0; k < int'(VECS[i][6:2]); k++) push_rx(8'(k));
            chk("R8 irq_rx_trig level", irq_rx_trig, int'(VECS[i][1]));
            chk("R13 rxrdy_n level", rxrdy_n, int'(VECS[i][0]));
        end

        // single-transfer signalling, FIFOs on, trigger 1
        wr_ctrl(8'h07);
        wr_thr(8'h5A);
        chk("R10 txrdy_n after write", txrdy_n, 1);
        chk("R9 irq_tx_req busy", irq_tx_req, 0);
        pop_tx(d);
        chk("R3 tx_char", d, 8'h5A);
        chk("R10 txrdy_n after drain", txrdy_n, 0);
        chk("R9 irq_tx_req empty", irq_tx_req, 1);
        push_rx(8'h33);
        chk("R11 rxrdy_n one char", rxrdy_n, 0);
        chk("R8 irq_rx_trig level 1", irq_rx_trig, 1);
        rd_rx(d);
        chk("R3 host_rdata", d, 8'h33);
        chk("R11 rxrdy_n drained", rxrdy_n, 1);

        // R3 and R6: full transmit queue, extra write ignored
        for (int k = 0; k < 16; k++) wr_thr(8'(k * 3));
        wr_thr(8'hFF);
        for (int k = 0; k < 16; k++) begin
            pop_tx(d);
            chk("R3 R6 tx order", d, k * 3);
        end
        chk("R6 tx queue empty after 16", tx_pending, 0);

        // R5: receive overrun, sticky until flush
        for (int k = 0; k < 17; k++) push_rx(8'(k + 100));
        chk("R5 overrun set", rx_overrun, 1);
        for (int k = 0; k < 16; k++) begin
            rd_rx(d);
            chk("R3 R5 rx order", d, k + 100);
        end
        chk("R5 rx drained", rxrdy_n, 1);
        chk("R5 overrun sticky", rx_overrun, 1);
        wr_ctrl(8'h03);
        chk("R7 overrun cleared by rx flush", rx_overrun, 0);

        // R12: block signalling transmit
        wr_ctrl(8'h0F);
        for (int k = 0; k < 15; k++) wr_thr(8'(k));
        chk("R12 txrdy_n 15 queued", txrdy_n, 0);
        chk("R9 irq_tx_req room", irq_tx_req, 1);
        wr_thr(8'hEE);
        chk("R12 txrdy_n full", txrdy_n, 1);
        chk("R9 irq_tx_req full", irq_tx_req, 0);
        pop_tx(d);
        chk("R12 txrdy_n room again", txrdy_n, 0);

        // R13: hysteresis at trigger 4
        wr_ctrl(8'h4B);
        for (int k = 0; k < 3; k++) push_rx(8'(k));
        chk("R13 below trigger", rxrdy_n, 1);
        push_rx(8'h03);
        chk("R13 trigger reached", rxrdy_n, 0);
        for (int k = 0; k < 3; k++) rd_rx(d);
        chk("R13 held with one left", rxrdy_n, 0);
        chk("R8 irq_rx_trig below", irq_rx_trig, 0);
        rd_rx(d);
        chk("R13 released when empty", rxrdy_n, 1);

        // R7: flush strobes
        chk("R7 tx has data before flush", tx_pending, 1);
        wr_ctrl(8'h4D);
        chk("R7 tx flushed", tx_pending, 0);
        push_rx(8'h11);
        push_rx(8'h22);
        wr_ctrl(8'h4B);
        chk("R7 rx flushed", rxrdy_n, 1);
        push_rx(8'h44);
        chk("R7 rx after flush", host_rdata, 8'h44);
        wr_ctrl(8'h4B);

        // R2: bits 5:4 ignored, mode 0, trigger 14; enable change flushes
        wr_ctrl(8'hF1);
        push_rx(8'h55);
        chk("R2 single signalling", rxrdy_n, 0);
        chk("R2 trigger 14 stored", irq_rx_trig, 0);
        wr_ctrl(8'h00);
        chk("R2 enable change flush", rxrdy_n, 1);

        // R4: one-deep holding registers
        wr_thr(8'hA1);
        wr_thr(8'hB2);
        pop_tx(d);
        chk("R4 tx holds first", d, 8'hA1);
        chk("R4 tx second dropped", tx_pending, 0);
        push_rx(8'hC3);
        chk("R8 level 1 without FIFO", irq_rx_trig, 1);
        push_rx(8'hD4);
        chk("R4 rx overrun", rx_overrun, 1);
        chk("R4 rx holds first", host_rdata, 8'hC3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule